// File: doc/BRIEF.md
# Cache Control and Profiling Register Block

This block is the software-facing register slice of an instruction and data cache. It sits on an APB bus and holds the cache's configuration word. The individual fields of that word drive the cache core as level outputs: cache off, direct-mapped mode, reset of the replacement bookkeeping, tag flush enable, the two performance switches for preload and sequential access, and four clock-gate override bits.

Two profiling counters record hit and miss pulses from the cache core. Software controls them through one bit of the configuration word. While that bit is 1, both counters are held at zero. While it is 0, each counter adds one per pulse and stops at its all-ones value instead of wrapping. Software reads the hit rate as hits / (hits + misses). A read-only status word shows whether a tag flush is in progress.

Top module: `cachereg_top`

## Requirements
- R1: After reset the configuration word reads 0x00000012, both counters read 0, `tag_flush_en` is 1 and every other control output is 0.
- R2: The configuration word is at byte offset 0x00. Its fields are: bit 0 cache disable, bit 1 tag flush enable, bit 3 replacement-state clear, bit 4 counter clear, bit 5 sequential-access disable, bit 6 preload disable, bits 10:7 clock-gate force (bit 7 drives `gate_force[0]`), and bit 11 direct-map enable. Each field appears on its output port one cycle after the write. Bit 2 and bits 31:12 ignore written data and read as 0.
- R3: The hit counter reads at offset 0x08 and is zero-extended to 32 bits. It adds one on every clock edge at which `hit_pulse` is 1 and the counter-clear bit is 0.
- R4: The miss counter reads at offset 0x0C and is zero-extended to 32 bits. It counts `miss_pulse` in the same way that R3 describes for hits. The two counters are independent, so simultaneous pulses advance both.
- R5: A counter that has reached its all-ones value (0xFFFFFFFF at the default width of CNT_W=32) keeps that value under further pulses.
- R6: While the counter-clear bit reads 1, both counters read 0. A write that sets the clear bit takes priority over a pulse in the same cycle, and the counter is 0 after that edge.
- R7: The status word at offset 0x10 has `flush_busy` in bit 0 and zeros in all other bits.
- R8: Writes to offsets 0x08, 0x0C, 0x10 and to unmapped offsets change no register. Reads of unmapped offsets return 0. Address bits 1:0 are ignored.
- R9: `pready` is always 1 and `pslverr` is always 0. Every transfer completes in its first access cycle, and read data is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer complete (always 1) |
| pslverr | output | 1 | Transfer error (always 0) |
| hit_pulse | input | 1 | One cycle per cache hit |
| miss_pulse | input | 1 | One cycle per cache miss |
| flush_busy | input | 1 | Tag flush in progress |
| cache_dis | output | 1 | Cache disabled |
| tag_flush_en | output | 1 | Tag flush enable |
| repl_clr | output | 1 | Clear replacement state |
| seq_dis | output | 1 | Sequential access disabled |
| preload_dis | output | 1 | Buffer preload disabled |
| gate_force | output | 4 | Clock-gate force enables |
| direct_map | output | 1 | Direct-mapped mode |

## Verification
The hardest state to reach from the ports is counter saturation. At full width it would take more than four billion pulses. The bench therefore builds the block with a 4-bit counter, drives pulse trains past 15, and checks that each counter holds at its top value. The second difficult case is a pulse that lands in the same cycle as a write setting the clear bit. The bench places a hit pulse exactly in the access phase of that write and then reads the counter back as zero.

// File: rtl/cachereg_pkg.sv
package cachereg_pkg;

    localparam int DATA_W = 32;

    // Word offsets (byte offset / 4)
    localparam int WOFF_CTRL = 0;
    localparam int WOFF_HIT  = 2;
    localparam int WOFF_MISS = 3;
    localparam int WOFF_STAT = 4;

    typedef struct packed {
        logic       direct_map;
        logic [3:0] gate_force;
        logic       preload_dis;
        logic       seq_dis;
        logic       cnt_clr;
        logic       repl_clr;
        logic       tag_flush_en;
        logic       cache_dis;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_HIT,
        SEL_MISS,
        SEL_STAT
    } rsel_e;

    function automatic ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.cache_dis    = w[0];
        c.tag_flush_en = w[1];
        c.repl_clr     = w[3];
        c.cnt_clr      = w[4];
        c.seq_dis      = w[5];
        c.preload_dis  = w[6];
        c.gate_force   = w[10:7];
        c.direct_map   = w[11];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w       = '0;
        w[0]    = c.cache_dis;
        w[1]    = c.tag_flush_en;
        w[3]    = c.repl_clr;
        w[4]    = c.cnt_clr;
        w[5]    = c.seq_dis;
        w[6]    = c.preload_dis;
        w[10:7] = c.gate_force;
        w[11]   = c.direct_map;
        return w;
    endfunction

    localparam logic [DATA_W-1:0] CTRL_RST_WORD = 32'h0000_0012;

endpackage

// File: rtl/cachereg_apb.sv
module cachereg_apb
    import cachereg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output logic              wr_ctrl,
    output rsel_e             rsel
);

    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic              access;

    always_comb begin
        widx    = paddr[ADDR_W-1:2];
        access  = psel && penable;
        wr_ctrl = access && pwrite && (widx == WIDX_W'(WOFF_CTRL));
        rsel    = SEL_NONE;
        if (psel && !pwrite) begin
            case (widx)
                WIDX_W'(WOFF_CTRL): rsel = SEL_CTRL;
                WIDX_W'(WOFF_HIT):  rsel = SEL_HIT;
                WIDX_W'(WOFF_MISS): rsel = SEL_MISS;
                WIDX_W'(WOFF_STAT): rsel = SEL_STAT;
                default:            rsel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/cachereg_ctrl.sv
module cachereg_ctrl
    import cachereg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl_d,
    output ctrl_t             ctrl_q
);

    typedef struct packed {
        ctrl_t ctrl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctrl = word_to_ctrl(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= word_to_ctrl(CTRL_RST_WORD);
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_d = st_d.ctrl;
    assign ctrl_q = st_q.ctrl;

endmodule

// File: rtl/cachereg_satcnt.sv
module cachereg_satcnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             pulse,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (pulse && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/cachereg_top.sv
module cachereg_top
    import cachereg_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 32
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              hit_pulse,
    input  logic              miss_pulse,
    input  logic              flush_busy,
    output logic              cache_dis,
    output logic              tag_flush_en,
    output logic              repl_clr,
    output logic              seq_dis,
    output logic              preload_dis,
    output logic [3:0]        gate_force,
    output logic              direct_map
);

    localparam int NCNT = 2;

    logic                       wr_ctrl;
    rsel_e                      rsel;
    ctrl_t                      ctrl_d, ctrl_q;
    logic [NCNT-1:0]            pulses;
    logic [NCNT-1:0][CNT_W-1:0] cnt_w;
    logic [NCNT-1:0][DATA_W-1:0] cnt_word;
    logic [CNT_W-1:0]           hit_cnt, miss_cnt;

    cachereg_apb #(.ADDR_W(ADDR_W)) u_apb (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .wr_ctrl (wr_ctrl),
        .rsel    (rsel)
    );

    cachereg_ctrl u_ctrl (
        .clk    (pclk),
        .rst_n  (presetn),
        .wr_en  (wr_ctrl),
        .wdata  (pwdata),
        .ctrl_d (ctrl_d),
        .ctrl_q (ctrl_q)
    );

    assign pulses = {miss_pulse, hit_pulse};

    // Clear uses the next control value so that a write setting it wins
    // over a pulse in the same cycle.
    for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
        cachereg_satcnt #(.CNT_W(CNT_W)) u_cnt (
            .clk   (pclk),
            .rst_n (presetn),
            .clr   (ctrl_d.cnt_clr),
            .pulse (pulses[gi]),
            .cnt   (cnt_w[gi])
        );
        always_comb begin
            cnt_word[gi]            = '0;
            cnt_word[gi][CNT_W-1:0] = cnt_w[gi];
        end
    end

    assign hit_cnt  = cnt_w[0];
    assign miss_cnt = cnt_w[1];

    always_comb begin
        case (rsel)
            SEL_CTRL: prdata = ctrl_to_word(ctrl_q);
            SEL_HIT:  prdata = cnt_word[0];
            SEL_MISS: prdata = cnt_word[1];
            SEL_STAT: prdata = {31'b0, flush_busy};
            default:  prdata = '0;
        endcase
    end

    assign pready       = 1'b1;
    assign pslverr      = 1'b0;
    assign cache_dis    = ctrl_q.cache_dis;
    assign tag_flush_en = ctrl_q.tag_flush_en;
    assign repl_clr     = ctrl_q.repl_clr;
    assign seq_dis      = ctrl_q.seq_dis;
    assign preload_dis  = ctrl_q.preload_dis;
    assign gate_force   = ctrl_q.gate_force;
    assign direct_map   = ctrl_q.direct_map;

endmodule

// File: rtl/cachereg_chk.sv
module cachereg_chk #(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 32
) (
    input logic              pclk,
    input logic              presetn,
    input logic              psel,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       prdata,
    input logic              pready,
    input logic              pslverr,
    input logic              flush_busy,
    input logic              clr_q,
    input logic [CNT_W-1:0]  hit_q,
    input logic [CNT_W-1:0]  miss_q
);

    localparam logic [CNT_W-1:0] TOP = '1;

    // R9
    bus_resp_chk: assert property (@(posedge pclk) disable iff (!presetn)
        pready && !pslverr);

    // R6
    clr_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
        clr_q |-> (hit_q == '0) && (miss_q == '0));

    // R5
    hit_sat_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (hit_q == TOP) |=> (hit_q == TOP) || (hit_q == '0));

    // R5
    miss_sat_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (miss_q == TOP) |=> (miss_q == TOP) || (miss_q == '0));

    // R3
    hit_step_chk: assert property (@(posedge pclk) disable iff (!presetn)
        1'b1 |=> (hit_q == $past(hit_q)) || (hit_q == $past(hit_q) + 1'b1) || (hit_q == '0));

    // R4
    miss_step_chk: assert property (@(posedge pclk) disable iff (!presetn)
        1'b1 |=> (miss_q == $past(miss_q)) || (miss_q == $past(miss_q) + 1'b1) || (miss_q == '0));

    // R7
    stat_read_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !pwrite && paddr[ADDR_W-1:2] == (ADDR_W-2)'(4)) |-> (prdata == {31'b0, flush_busy}));

    // R2
    rsvd_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !pwrite && paddr[ADDR_W-1:2] == '0) |-> (prdata[31:12] == '0) && !prdata[2]);

endmodule

bind cachereg_top cachereg_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .pclk       (pclk),
    .presetn    (presetn),
    .psel       (psel),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .prdata     (prdata),
    .pready     (pready),
    .pslverr    (pslverr),
    .flush_busy (flush_busy),
    .clr_q      (ctrl_q.cnt_clr),
    .hit_q      (hit_cnt),
    .miss_q     (miss_cnt)
);

// File: tb/cachereg_top_tb.sv
module cachereg_top_tb;

    localparam int ADDR_W = 12;
    localparam int CNT_W  = 4;
    localparam int TOPV   = (1 << CNT_W) - 1;

    logic              pclk = 1'b0;
    logic              presetn = 1'b0;
    logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [31:0]       pwdata = '0;
    logic [31:0]       prdata;
    logic              pready, pslverr;
    logic              hit_pulse = 1'b0, miss_pulse = 1'b0, flush_busy = 1'b0;
    logic              cache_dis, tag_flush_en, repl_clr, seq_dis, preload_dis, direct_map;
    logic [3:0]        gate_force;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #4 pclk = ~pclk;

    cachereg_top #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .hit_pulse(hit_pulse),
        .miss_pulse(miss_pulse), .flush_busy(flush_busy), .cache_dis(cache_dis),
        .tag_flush_en(tag_flush_en), .repl_clr(repl_clr), .seq_dis(seq_dis),
        .preload_dis(preload_dis), .gate_force(gate_force), .direct_map(direct_map)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic apb_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge pclk);
        penable = 1'b1;
        #1;
        d = prdata;
        total++;
        if (pready !== 1'b1 || pslverr !== 1'b0) begin
            bad++;
            $display("FAIL R9 actual=%b%b expected=10", pready, pslverr);
        end
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic pulses(input int n, input logic h, input logic m);
        if (n > 0) begin
            @(negedge pclk);
            hit_pulse = h; miss_pulse = m;
            repeat (n) @(negedge pclk);
            hit_pulse = 1'b0; miss_pulse = 1'b0;
        end
    endtask

    function automatic logic [31:0] outs_word();
        return {20'b0, direct_map, gate_force, preload_dis, seq_dis, 1'b0,
                repl_clr, 1'b0, tag_flush_en, cache_dis};
    endfunction

    initial begin
        forever begin
            @(posedge pclk);
            cycles++;
            if (cycles > 150000) begin
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] rd;
        int eh, em;
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk);
        // R1 reset state
        check("R1 outputs", outs_word(), 32'h0000_0002);
        apb_read(12'h000, rd); check("R1 ctrl", rd, 32'h0000_0012);
        apb_read(12'h008, rd); check("R1 hit", rd, 0);
        apb_read(12'h00C, rd); check("R1 miss", rd, 0);

        // R2 exhaustive sweep of the 12 low bits, upper bits set
        for (int v = 0; v < 4096; v++) begin
            apb_write(12'h000, {20'hFFFFF, 12'(v)});
            check("R2 outputs", outs_word(), 32'(v) & 32'h0000_0FEB);
            apb_read(12'h000, rd);
            check("R2 readback", rd, 32'(v) & 32'h0000_0FFB);
        end

        // R7 status
        flush_busy = 1'b1;
        apb_read(12'h010, rd); check("R7 busy", rd, 1);
        flush_busy = 1'b0;
        apb_read(12'h010, rd); check("R7 idle", rd, 0);

        // R3 R4 R5 pulse count sweep (clear bit off)
        for (int n = 0; n <= 20; n++) begin
            apb_write(12'h000, 32'h10);
            apb_write(12'h000, 32'h00);
            pulses(n, 1'b1, (n % 3) == 0);
            eh = (n > TOPV) ? TOPV : n;
            em = ((n % 3) == 0) ? eh : 0;
            apb_read(12'h008, rd); check("R3/R5 hit", rd, 32'(eh));
            apb_read(12'h00C, rd); check("R4/R5 miss", rd, 32'(em));
        end

        // R4 interleaved patterns, both counters independent
        apb_write(12'h000, 32'h10);
        apb_write(12'h000, 32'h00);
        eh = 0; em = 0;
        for (int i = 0; i < 12; i++) begin
            pulses(1, (i % 2) == 0, (i % 4) != 3);
            if ((i % 2) == 0) eh++;
            if ((i % 4) != 3) em++;
        end
        apb_read(12'h008, rd); check("R3 interleave hit", rd, 32'(eh));
        apb_read(12'h00C, rd); check("R4 interleave miss", rd, 32'(em));

        // R8 ignored writes, unmapped reads, low address bits
        apb_write(12'h008, 32'hFFFF_FFFF);
        apb_write(12'h00C, 32'h0);
        apb_write(12'h010, 32'hFFFF_FFFF);
        apb_write(12'h004, 32'h0000_0FFF);
        apb_read(12'h008, rd); check("R8 hit kept", rd, 32'(eh));
        apb_read(12'h00C, rd); check("R8 miss kept", rd, 32'(em));
        apb_read(12'h000, rd); check("R8 ctrl kept", rd, 0);
        apb_read(12'h004, rd); check("R8 unmapped 04", rd, 0);
        apb_read(12'h014, rd); check("R8 unmapped 14", rd, 0);
        apb_read(12'hFFC, rd); check("R8 unmapped FFC", rd, 0);
        apb_read(12'h00B, rd); check("R8 low bits", rd, 32'(eh));

        // R6 hold at zero while clear set
        apb_write(12'h000, 32'h10);
        pulses(5, 1'b1, 1'b1);
        apb_read(12'h008, rd); check("R6 hit held", rd, 0);
        apb_read(12'h00C, rd); check("R6 miss held", rd, 0);

        // R6 clear write wins over a same-cycle pulse
        apb_write(12'h000, 32'h00);
        pulses(3, 1'b1, 1'b0);
        apb_read(12'h008, rd); check("R6 precount", rd, 3);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b1; paddr = 12'h000; pwdata = 32'h10;
        @(negedge pclk);
        penable = 1'b1; hit_pulse = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; hit_pulse = 1'b0;
        apb_read(12'h008, rd); check("R6 clear priority", rd, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule